// File: doc/BRIEF.md
# Tone Steering and Code Latch

This block sits behind a dual-tone classifier. The classifier supplies a raw "pair present" flag and a 4-bit key code. The block qualifies that flag in time, using clock-tick counters instead of an analog RC delay. It drives an early-steering output that mirrors the raw flag. A tone is accepted only after the flag has stayed high for a programmable present-guard time. A tone is released only after the flag has stayed low for a separate absent-guard time. Between those two events, short drop-outs are bridged.

On acceptance, the key code is captured into a holding register. A data-valid output rises a programmable setup time later, so the code is stable before the strobe. On release, data-valid falls, but the held code stays until the next accepted tone. An output-enable input controls the data bus. Because the bus is presented as data plus a drive-enable, the high-impedance buffer belongs in the pad ring.

All three times are parameters in clock ticks. The defaults assume a 50 MHz clock:
- present guard: about 30 ms, which sits between the 20 ms reject bound and the 42 ms accept bound for tone bursts;
- absent guard: about 25 ms;
- setup time: 4.5 ms.

A power-down input forces both strobes low and restarts qualification.

Top module: `tone_steer_latch`

## Requirements
- R1: `est` equals `det_raw` in the same cycle whenever `pwr_down` is low, and is 0 whenever `pwr_down` is high.
- R2: A tone is accepted only when `det_raw` is high on PRESENT_TICKS consecutive clock edges. Any low edge restarts the count, and a shorter burst latches nothing and never raises `dv`.
- R3: At the acceptance edge (the PRESENT_TICKS-th consecutive high edge), the 4-bit `det_code` sampled on that edge is loaded into the held code, while `dv` is still 0.
- R4: `dv` rises exactly SETUP_TICKS clock edges after the code is loaded, provided no release or power-down intervenes.
- R5: After acceptance, `det_raw` low on ABSENT_TICKS consecutive edges releases the tone, and `dv` falls on that edge.
- R6: A drop-out of `det_raw` lasting fewer than ABSENT_TICKS edges neither releases the tone nor drops `dv`, and the returning detection does not reload the code.
- R7: The held code does not change while a tone is accepted, even if `det_code` changes. It also stays unchanged after release, until the next acceptance.
- R8: When `pwr_down` is high, `dv` is 0 from the next edge on, including an edge on which `dv` would otherwise have risen. After `pwr_down` clears, a tone needs a full PRESENT_TICKS qualification again. The held code is retained throughout.
- R9: With `oe` = 1, `bus_en` = 1 and `bus_data` carries the held code bit for bit (bit 0 is the code's bit 0). With `oe` = 0, `bus_en` = 0 and `bus_data` = 4'b0000. After reset the held code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down: forces strobes low, restarts qualification |
| det_raw | input | 1 | Raw tone-pair detect flag from the classifier |
| det_code | input | 4 | Key code from the classifier |
| oe | input | 1 | Data bus output enable |
| est | output | 1 | Early steering, follows the raw detect flag |
| dv | output | 1 | Data valid strobe |
| bus_en | output | 1 | Drive enable for the data bus buffer |
| bus_data | output | 4 | Held key code, zero when not enabled |

## Verification
Power-down and setup completion can land on the same edge. If power-down wins, `dv` never rises. If the setup timer wins, a strobe appears while the part is powered down. The bench provokes this collision by holding detection for one edge fewer than the present-plus-setup time and then raising `pwr_down` for exactly the edge on which `dv` would rise. It judges the outcome by seeing `dv` stay 0 on that edge and afterwards, while the held code is still readable on the bus.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REL  = 2'd2
  } steer_st_t;

  // Counter width able to hold 0 .. lim-1.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  // True on the last tick of a window of lim ticks.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/tsl_guard_timer.sv
module tsl_guard_timer import tsl_pkg::*; #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW = cnt_width(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);

  logic [CW-1:0] cnt_q;

  // Fires on the LIMIT-th consecutive enabled edge.
  assign hit = en && !clr && at_limit(32'(cnt_q), 32'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else if (en)         cnt_q <= cnt_q + 1'b1;
  end

  // R2 / R5 / R4: a window counter never passes its limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LIMIT);

endmodule

// File: rtl/tsl_steer_fsm.sv
module tsl_steer_fsm import tsl_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_down,
  input  logic      det_raw,
  input  logic      pres_hit,
  input  logic      abs_hit,
  input  logic      setup_hit,
  output steer_st_t state,
  output logic      dv,
  output logic      ev_accept,
  output logic      ev_release
);

  steer_st_t st_q, st_d;
  logic      dv_q;
  logic      idle;

  assign idle       = (st_q == ST_IDLE);
  assign ev_accept  = idle && pres_hit;
  assign ev_release = !idle && abs_hit;

  always_comb begin
    st_d = st_q;
    if (pwr_down) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pres_hit) st_d = ST_ACC;
        ST_ACC: begin
          if (abs_hit)       st_d = ST_IDLE;
          else if (!det_raw) st_d = ST_REL;
        end
        ST_REL: begin
          if (abs_hit)      st_d = ST_IDLE;
          else if (det_raw) st_d = ST_ACC;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      dv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // Power-down and release take priority over setup completion.
      if (pwr_down || ev_release) dv_q <= 1'b0;
      else if (setup_hit)         dv_q <= 1'b1;
    end
  end

  assign state = st_q;
  assign dv    = dv_q;

  // R4: the strobe only rises with a tone accepted
  p_dv_needs_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> (st_q != ST_IDLE));

  // R5: release drops the strobe and returns to idle
  p_release_drops_dv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (!dv_q && st_q == ST_IDLE));

  // R8: power-down clears the strobe and qualification state
  p_pd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!dv_q && st_q == ST_IDLE));

endmodule

// File: rtl/tsl_code_latch.sv
module tsl_code_latch #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              oe,
  output logic [CODE_W-1:0] code_q,
  output logic              bus_en,
  output logic [CODE_W-1:0] bus_data
);

  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= code_in;
  end

  assign code_q   = hold_q;
  assign bus_en   = oe;
  assign bus_data = oe ? hold_q : '0;

endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch import tsl_pkg::*; #(
  parameter int unsigned PRESENT_TICKS = 1_500_000,
  parameter int unsigned ABSENT_TICKS  = 1_250_000,
  parameter int unsigned SETUP_TICKS   = 225_000,
  parameter int unsigned CODE_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              det_raw,
  input  logic [CODE_W-1:0] det_code,
  input  logic              oe,
  output logic              est,
  output logic              dv,
  output logic              bus_en,
  output logic [CODE_W-1:0] bus_data
);

  steer_st_t         state;
  logic              idle;
  logic              pres_hit, abs_hit, setup_hit;
  logic              ev_accept, ev_release;
  logic [CODE_W-1:0] code_q;

  assign idle = (state == ST_IDLE);
  assign est  = det_raw && !pwr_down;

  // Present guard: consecutive high edges while idle.
  tsl_guard_timer #(.LIMIT(PRESENT_TICKS)) u_pres (
    .clk(clk), .rst_n(rst_n),
    .clr(pwr_down || !det_raw || !idle),
    .en (det_raw && idle),
    .hit(pres_hit)
  );

  // Absent guard: consecutive low edges while a tone is held.
  tsl_guard_timer #(.LIMIT(ABSENT_TICKS)) u_abs (
    .clk(clk), .rst_n(rst_n),
    .clr(pwr_down || det_raw || idle),
    .en (!det_raw && !idle),
    .hit(abs_hit)
  );

  // Setup delay from code load to strobe.
  tsl_guard_timer #(.LIMIT(SETUP_TICKS)) u_setup (
    .clk(clk), .rst_n(rst_n),
    .clr(pwr_down || idle),
    .en (!idle && !dv),
    .hit(setup_hit)
  );

  tsl_steer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pwr_down(pwr_down), .det_raw(det_raw),
    .pres_hit(pres_hit), .abs_hit(abs_hit), .setup_hit(setup_hit),
    .state(state), .dv(dv),
    .ev_accept(ev_accept), .ev_release(ev_release)
  );

  tsl_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .load(ev_accept), .code_in(det_code), .oe(oe),
    .code_q(code_q), .bus_en(bus_en), .bus_data(bus_data)
  );

  // R7: held code is frozen while the strobe is up
  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && !pwr_down) |=> $stable(code_q));

  // R3: a code load never coincides with a raised strobe
  p_load_before_dv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !dv);

endmodule

// File: tb/sim_tone_steer_latch.sv
`timescale 1ns/1ps
module sim_tone_steer_latch;

  localparam int P   = 20;
  localparam int A   = 12;
  localparam int S   = 5;
  localparam int GAP = 15;

  logic       clk = 1'b0;
  logic       rst_n, pwr_down, det_raw, oe;
  logic [3:0] det_code;
  logic       est, dv, bus_en;
  logic [3:0] bus_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tone_steer_latch #(.PRESENT_TICKS(P), .ABSENT_TICKS(A), .SETUP_TICKS(S)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .det_raw(det_raw),
    .det_code(det_code), .oe(oe), .est(est), .dv(dv),
    .bus_en(bus_en), .bus_data(bus_data)
  );

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] gap;
    logic [3:0] code;
    logic       acc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd19, 8'd15, 4'h3, 1'b0},
    '{8'd20, 8'd15, 4'h3, 1'b1},
    '{8'd5,  8'd15, 4'h9, 1'b0},
    '{8'd19, 8'd1,  4'h6, 1'b0},
    '{8'd19, 8'd15, 4'h6, 1'b0},
    '{8'd40, 8'd15, 4'hC, 1'b1},
    '{8'd30, 8'd15, 4'h0, 1'b1},
    '{8'd25, 8'd15, 4'hF, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] held;
    logic       seen;
    rst_n = 1'b0; pwr_down = 1'b0; det_raw = 1'b0; oe = 1'b1; det_code = 4'h0;
    tick(3);
    chk("R9 reset dv", dv, 0);
    chk("R1 reset est", est, 0);
    chk("R9 reset bus", bus_data, 4'h0);
    chk("R9 reset bus_en", bus_en, 1);
    rst_n = 1'b1;
    tick(1);

    // Acceptance timing
    det_code = 4'h5; det_raw = 1'b1; #1;
    chk("R1 est follows high", est, 1);
    tick(P - 1);
    chk("R2 not yet accepted", bus_data, 4'h0);
    tick(1);
    chk("R3 code latched", bus_data, 4'h5);
    chk("R3 dv still low", dv, 0);
    tick(S - 1);
    chk("R4 dv before setup", dv, 0);
    tick(1);
    chk("R4 dv after setup", dv, 1);
    det_code = 4'hA;
    tick(3);
    chk("R7 code change ignored", bus_data, 4'h5);

    // Short drop-out is bridged
    det_raw = 1'b0; #1;
    chk("R1 est follows low", est, 0);
    tick(A - 1);
    chk("R6 dropout keeps dv", dv, 1);
    det_raw = 1'b1;
    tick(P + 2);
    chk("R6 dv held after return", dv, 1);
    chk("R6 no relatch", bus_data, 4'h5);

    // Release
    det_raw = 1'b0;
    tick(A - 1);
    chk("R5 dv before release", dv, 1);
    tick(1);
    chk("R5 dv released", dv, 0);
    chk("R7 code held after release", bus_data, 4'h5);

    // Bus gating
    oe = 1'b0; #1;
    chk("R9 oe low bus_en", bus_en, 0);
    chk("R9 oe low data", bus_data, 4'h0);
    oe = 1'b1; #1;
    chk("R9 oe high data", bus_data, 4'h5);
    tick(2);

    // Table of bursts
    held = 4'h5;
    foreach (VEC[i]) begin
      det_code = VEC[i].code;
      det_raw  = 1'b1;
      seen     = 1'b0;
      for (int k = 0; k < int'(VEC[i].hi); k++) begin
        tick(1);
        if (dv) seen = 1'b1;
      end
      det_raw = 1'b0;
      for (int k = 0; k < int'(VEC[i].gap); k++) begin
        tick(1);
        if (dv) seen = 1'b1;
      end
      if (VEC[i].acc) held = VEC[i].code;
      chk($sformatf("R2 vec%0d accept", i), seen, VEC[i].acc);
      chk($sformatf("R3 vec%0d code", i), bus_data, held);
      chk($sformatf("R5 vec%0d dv idle", i), dv, 0);
    end

    // Power-down during a held tone
    det_code = 4'h7; det_raw = 1'b1;
    tick(P + S);
    chk("R4 dv up before pd", dv, 1);
    pwr_down = 1'b1; #1;
    chk("R1 est low in pd", est, 0);
    tick(1);
    chk("R8 pd drops dv", dv, 0);
    pwr_down = 1'b0; det_code = 4'h2;
    tick(P - 1);
    chk("R8 requalify pending", bus_data, 4'h7);
    tick(1);
    chk("R8 requalified", bus_data, 4'h2);
    tick(S);
    chk("R8 dv after requalify", dv, 1);
    det_raw = 1'b0;
    tick(A + 2);

    // Power-down on the edge where dv would rise
    det_code = 4'h4; det_raw = 1'b1;
    tick(P + S - 1);
    chk("R4 dv not yet", dv, 0);
    pwr_down = 1'b1;
    tick(1);
    chk("R8 collision dv low", dv, 0);
    chk("R8 code retained", bus_data, 4'h4);
    pwr_down = 1'b0; det_raw = 1'b0;
    tick(S + 2);
    chk("R8 no late strobe", dv, 0);

    finish_run();
  end

endmodule